// File: doc/BRIEF.md
# Edge Event Counter Compare Flags

This block counts rising edges on six separate external inputs, channels A to F. Each channel has its own 8-bit counter and its own 8-bit compare value. A compare-match flag for a channel goes high when a new edge arrives while that channel's counter already holds the compare value. Reaching equality by itself does not raise the flag. Each input is synchronised to the block clock and edge-detected before it reaches its counter.

Software sees the block through a simple register bus. One 16-bit status word carries the six flags. Each counter and each compare value has its own address. A flag can only be cleared by a two-step handshake: first a status read that returns the flag as 1, then a write of 0 to that bit. A stray write of 0 therefore cannot discard an event that software has not yet seen.

Top module: `evt_match_timer`

## Requirements
- R1: After reset, all six flags are 0, all counters and compare values are 0, and the status word reads 0x0000.
- R2: In the status word (address 0), bit 0 holds the channel A flag, bit 1 channel B, and so on up to bit 5 for channel F. Bits 15 to 6 always read 0, and writing them changes nothing.
- R3: The counters of channels A to F sit at addresses 1 to 6, and the compare values of A to F sit at addresses 8 to 13. Both kinds are readable and writable in bits 7:0, with bits 15:8 reading 0. A write takes effect at the clock edge on which it is presented. Read data is combinational. Unmapped addresses read 0.
- R4: A channel's flag becomes 1 when a detected edge arrives while its counter equals its compare value. The edge that brings the counter up to the compare value does not set the flag.
- R5: A write of 0 to a flag bit clears the flag only if the most recent status read returned that flag as 1. A write of 0 with no such read leaves the flag at 1.
- R6: Writing 1 to a flag bit has no effect on that flag.
- R7: A counter adds 1 for each detected rising edge on its input and wraps from 255 to 0.
- R8: Each input passes through two synchroniser flops and a rising-edge detector. An input held high for many cycles is counted once. The count becomes visible on the third clock edge after the input rises.
- R9: If a setting edge and a valid clearing write fall in the same clock cycle, the flag stays 1.
- R10: Channels are independent. An edge on one input changes neither the counter nor the flag of any other channel.
- R11: Any write to the status word uses up the read-while-set permission. A later write of 0, with no new status read in between, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 6 | External event inputs, bit 0 = channel A |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, used to capture read-while-set permission |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |

## Verification
The bench separates the edge that brings the counter up to the compare value from the edge that arrives while the two are already equal. A design that flagged on equality would set the flag one edge too early, and the bench would catch it. It tries to clear a flag with a write of 0 that has no read before it, and with a write of 0 after an intervening write of 1. A design that ignored or kept the read permission would clear the flag in those cases. It also times a clearing write to land in the same cycle as a setting edge, so a design that let the clear win would lose the event. Finally, it checks a counter wrapping at 255, an input held high for a long time, and traffic on a single channel. These catch a counter that saturates, an edge detector that counts levels, and channels that share state.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  localparam int NCH = 6;
  localparam int CW  = 8;
  localparam int AW  = 5;
  localparam int DW  = 16;

  localparam logic [AW-1:0] ADDR_STATUS   = AW'(0);
  localparam logic [AW-1:0] ADDR_CNT_BASE = AW'(1);
  localparam logic [AW-1:0] ADDR_CMP_BASE = AW'(8);

  typedef logic [CW-1:0] cnt_t;

  // Next counter value: increment with natural wrap at the counter width.
  function automatic cnt_t next_count(input cnt_t c);
    return c + cnt_t'(1);
  endfunction

  // Compare-match condition evaluated when an edge arrives.
  function automatic logic is_match(input cnt_t c, input cnt_t ref_v);
    return (c == ref_v);
  endfunction

  // Flags that a status write is allowed to clear.
  function automatic logic [NCH-1:0] clear_mask(input logic [NCH-1:0] armed,
                                                input logic [NCH-1:0] wbits);
    return armed & ~wbits;
  endfunction
endpackage

// File: rtl/evt_edge_sync.sv
`timescale 1ns/1ps
module evt_edge_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] rise_pulse
);
  for (genvar g = 0; g < W; g++) begin : g_sync
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= raw_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_pulse[g] = sync_q & ~prev_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse[g] |=> !rise_pulse[g]); // R8
  end
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel
  import evt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  edge_pulse,
  input  logic  cnt_we,
  input  logic  cmp_we,
  input  cnt_t  wr_val,
  input  logic  clr_req,
  output cnt_t  cnt_q,
  output cnt_t  cmp_q,
  output logic  flag_q,
  output logic  set_evt
);
  assign set_evt = edge_pulse & is_match(cnt_q, cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_we)       cnt_q <= wr_val;
    else if (edge_pulse)   cnt_q <= next_count(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= wr_val;
  end

  // Set has priority over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  AST_FLAG_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(edge_pulse)); // R4
  AST_FLAG_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && (cnt_q == cmp_q) && clr_req) |=> flag_q); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && !cnt_we) |=> (cnt_q == cnt_t'($past(cnt_q) + 8'd1))); // R7
  AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_pulse && !cnt_we) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/evt_status_arm.sv
`timescale 1ns/1ps
module evt_status_arm
  import evt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_rd,
  input  logic           st_wr,
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] clr_req
);
  logic [NCH-1:0] arm_q;

  // Permission captured on a status read, used up by any status write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     arm_q <= '0;
    else if (st_wr) arm_q <= '0;
    else if (st_rd) arm_q <= flags;
  end

  assign clr_req = st_wr ? clear_mask(arm_q, wbits) : '0;

  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (arm_q == '0)); // R11
  AST_CLR_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & ~arm_q) == '0)); // R5
endmodule

// File: rtl/evt_match_timer.sv
`timescale 1ns/1ps
module evt_match_timer
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    evt_in,
  input  logic [4:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata
);
  localparam int PADW = DW - NCH;

  logic [NCH-1:0] edge_pulse;
  logic [NCH-1:0] flags;
  logic [NCH-1:0] set_evt;
  logic [NCH-1:0] clr_req;
  logic [NCH-1:0] cnt_we, cmp_we;
  cnt_t           cnt_v [NCH];
  cnt_t           cmp_v [NCH];
  logic           st_rd, st_wr;
  logic           unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:CW];
  assign st_rd = bus_rd & (bus_addr == ADDR_STATUS);
  assign st_wr = bus_wr & (bus_addr == ADDR_STATUS);

  evt_edge_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(evt_in), .rise_pulse(edge_pulse)
  );

  evt_status_arm u_arm (
    .clk(clk), .rst_n(rst_n), .st_rd(st_rd), .st_wr(st_wr),
    .flags(flags), .wbits(bus_wdata[NCH-1:0]), .clr_req(clr_req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] CNT_ADDR = ADDR_CNT_BASE + AW'(i);
    localparam logic [AW-1:0] CMP_ADDR = ADDR_CMP_BASE + AW'(i);
    assign cnt_we[i] = bus_wr & (bus_addr == CNT_ADDR);
    assign cmp_we[i] = bus_wr & (bus_addr == CMP_ADDR);

    evt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse[i]),
      .cnt_we(cnt_we[i]), .cmp_we(cmp_we[i]), .wr_val(bus_wdata[CW-1:0]),
      .clr_req(clr_req[i]), .cnt_q(cnt_v[i]), .cmp_q(cmp_v[i]),
      .flag_q(flags[i]), .set_evt(set_evt[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_STATUS) bus_rdata = {{PADW{1'b0}}, flags};
    for (int k = 0; k < NCH; k++) begin
      if (bus_addr == ADDR_CNT_BASE + AW'(k)) bus_rdata = {{(DW-CW){1'b0}}, cnt_v[k]};
      if (bus_addr == ADDR_CMP_BASE + AW'(k)) bus_rdata = {{(DW-CW){1'b0}}, cmp_v[k]};
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_STATUS) |-> (bus_rdata[DW-1:NCH] == '0)); // R2
  AST_FLAG_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt))); // R4
  AST_FLAGS_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt == '0) && !st_wr) |=> $stable(flags)); // R6
endmodule

// File: tb/sim_evt_match_timer.sv
`timescale 1ns/1ps
module sim_evt_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt_in = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {ch[3], preset[8], compare[8], edges[4], exp_count[8], exp_flag[1]}
  localparam logic [31:0] VEC [8] = '{
    {3'd0, 8'd0,   8'd3,   4'd3, 8'd3,  1'b0},
    {3'd0, 8'd0,   8'd3,   4'd4, 8'd4,  1'b1},
    {3'd1, 8'd0,   8'd0,   4'd1, 8'd1,  1'b1},
    {3'd2, 8'd254, 8'd255, 4'd2, 8'd0,  1'b1},
    {3'd3, 8'd255, 8'd5,   4'd1, 8'd0,  1'b0},
    {3'd4, 8'd10,  8'd12,  4'd5, 8'd15, 1'b1},
    {3'd5, 8'd0,   8'd7,   4'd2, 8'd2,  1'b0},
    {3'd5, 8'd6,   8'd7,   4'd1, 8'd7,  1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_edges(input logic [5:0] m, input int n, input int hold);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); evt_in = m;
      repeat (hold) @(negedge clk);
      evt_in = '0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic clear_all();
    logic [15:0] d;
    bus_read(5'd0, d);
    bus_write(5'd0, 16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    bus_read(5'd0, d);  check("R1 status", d, 16'h0000);
    bus_read(5'd3, d);  check("R1 counter", d, 16'h0000);
    bus_read(5'd12, d); check("R1 compare", d, 16'h0000);
    // R8 synchroniser latency: counter still 0 after reset release before any edge
    @(negedge clk); rst_n = 1'b1;
    bus_read(5'd0, d);  check("R1 status after release", d, 16'h0000);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      logic [2:0] ch; logic [7:0] pre, cmp, ecnt; logic [3:0] n; logic ef;
      {ch, pre, cmp, n, ecnt, ef} = VEC[v];
      clear_all();
      bus_write(5'(8 + ch), {8'h0, cmp});
      bus_write(5'(1 + ch), {8'h0, pre});
      bus_read(5'(8 + ch), d); check("R3 compare readback", d, {8'h0, cmp});
      pulse_edges(6'(1 << ch), int'(n), 3);
      bus_read(5'(1 + ch), d); check("R7 count", d, {8'h0, ecnt});
      bus_read(5'd0, d);
      check("R4 flag", d, ef ? 16'(1 << ch) : 16'h0000);
    end

    // R2: reserved bits ignored, R6: writing 1 does not set flags
    clear_all();
    bus_write(5'd0, 16'hFFFF);
    bus_read(5'd0, d); check("R2/R6 write ones", d, 16'h0000);
    bus_read(5'd20, d); check("R3 unmapped", d, 16'h0000);

    // R8: long high counted once; R10: other channels untouched
    for (int c = 0; c < 6; c++) begin
      bus_write(5'(1 + c), 16'h0000);
      bus_write(5'(8 + c), 16'h0050);
    end
    pulse_edges(6'b000010, 1, 30);
    bus_read(5'd2, d); check("R8 long high once", d, 16'h0001);
    bus_read(5'd1, d); check("R10 ch A untouched", d, 16'h0000);
    bus_read(5'd6, d); check("R10 ch F untouched", d, 16'h0000);

    // All channels together, matching (cmp 1, counter 1 after one edge)
    for (int c = 0; c < 6; c++) begin
      bus_write(5'(8 + c), 16'h0001);
      bus_write(5'(1 + c), 16'h0000);
    end
    clear_all();
    pulse_edges(6'h3F, 2, 3);
    // R5: write 0 without a read since the set leaves flags
    bus_write(5'd0, 16'h0000);
    bus_read(5'd0, d); check("R5 unarmed write", d, 16'h003F);
    // R11: status write of ones uses up permission
    bus_write(5'd0, 16'hFFFF);
    bus_write(5'd0, 16'h0000);
    bus_read(5'd0, d); check("R11 permission consumed", d, 16'h003F);
    // R5: read-then-write-0 on selected bits clears only those
    bus_write(5'd0, 16'h0005);
    bus_read(5'd0, d); check("R5 selective clear", d, 16'h0005);
    bus_read(5'd0, d);
    bus_write(5'd0, 16'h0000);
    bus_read(5'd0, d); check("R5 full clear", d, 16'h0000);

    // R9: set and valid clear in the same cycle
    bus_write(5'd8, 16'h0002);
    bus_write(5'd1, 16'h0002);
    pulse_edges(6'b000001, 1, 3);
    bus_write(5'd8, 16'h0003);
    bus_read(5'd0, d); check("R9 armed flag", d, 16'h0001);
    @(negedge clk); evt_in = 6'b000001;
    @(negedge clk); @(negedge clk);
    bus_addr = 5'd0; bus_wdata = 16'h0000; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; evt_in = '0;
    repeat (4) @(negedge clk);
    bus_read(5'd0, d); check("R9 set wins", d, 16'h0001);
    bus_read(5'd1, d); check("R9 count advanced", d, 16'h0004);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(5'd0, d); check("R1 reset clears flags", d, 16'h0000);
    bus_read(5'd1, d); check("R1 reset clears counter", d, 16'h0000);

    finish_run();
  end
endmodule